// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block sits between a CAN receiver and its receive FIFO. For each completed frame it decides whether to store or discard it. It compares the frame's identifier and RTR bit, and for base-format frames also the first two data bytes, with a 32-bit programmable code word. A 32-bit mask word marks which bit positions are ignored. Each word is written one byte at a time through a small write port. Frames that do not match are discarded without any other effect. The same code and mask words serve both frame formats. Their bits are read as different fields for an 11-bit identifier than for a 29-bit identifier.

A frame enters on a valid/ready stream. `in_ready` is always high, so the filter never applies back-pressure. A transfer happens on every clock edge where `in_valid` is high, and frames may arrive on back-to-back cycles. One clock after each transfer the filter raises `res_valid` for one cycle. `res_accept` says whether the frame matched. The receiver writes the frame into the FIFO on `res_valid & res_accept`. The result stream has no ready input, so the FIFO side must take each decision in the cycle it appears.

Top module: `can_accept_filter`

## Requirements
- R1: After reset the code word is all zeros, the mask word is all ones and `res_valid` is low, so every frame of either format is accepted.
- R2: Each transfer (`in_valid` high at a clock edge) gives `res_valid` high for exactly the next cycle. A cycle with no transfer gives `res_valid` low in the next cycle. `res_accept` is high only while `res_valid` is high.
- R3: A mask bit of 1 makes its bit position match whatever the frame holds. A mask bit of 0 requires the frame bit to equal the code bit. A frame is accepted only when every position matches.
- R4: Base format (`in_ext`=0): the identifier `in_id[10:0]` occupies code bits 31:21, RTR bit 20, data byte 0 bits 19:12 and data byte 1 bits 11:4, each MSB first. Bits 3:0 always match.
- R5: Base format: data byte 0 is compared only when `in_dlc` is 1 or more. Data byte 1 is compared only when `in_dlc` is 2 or more. A byte that is absent always matches.
- R6: Extended format (`in_ext`=1): `in_id[28:0]` occupies code bits 31:3 and RTR bit 2. Bits 1:0 and both data bytes always match.
- R7: `cfg_addr` 0 to 3 write code bytes and 4 to 7 write mask bytes. Byte n (address n or 4+n) holds word bits 31-8n down to 24-8n. A write governs every frame transferred in a later cycle.
- R8: `in_ready` is always high. Frames transferred on consecutive cycles each get their own decision on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: 0-3 code bytes, 4-7 mask bytes |
| cfg_wdata | input | 8 | Register write data |
| in_valid | input | 1 | Frame-complete strobe (stream valid) |
| in_ready | output | 1 | Stream ready, always high |
| in_ext | input | 1 | 1 = 29-bit identifier frame, 0 = 11-bit |
| in_id | input | 29 | Identifier, right-aligned for base frames |
| in_rtr | input | 1 | Remote request bit |
| in_dlc | input | 4 | Data length code |
| in_data0 | input | 8 | First data byte |
| in_data1 | input | 8 | Second data byte |
| res_valid | output | 1 | Decision strobe, one cycle after the transfer |
| res_accept | output | 1 | 1 = store frame, 0 = discard |

## Verification
The vector table pairs frames that match the code exactly with frames that differ in a single field: an identifier bit, RTR, or one data byte. This separates a correct field placement from a shifted or swapped one in both formats. Patterns with `in_dlc` of 0, 1 and 2 against mismatching data show whether each data byte is gated by its own length threshold. Partial masks cover some of the differing identifier bits in one case and all of them in another, and a code word with its always-matching low bits set tells ignored positions apart from compared ones. Directed runs add back-to-back transfers with alternating outcomes, a single mask-byte write that shows the byte order, and the fully open state after reset.

// File: rtl/can_af_pkg.sv
package can_af_pkg;
  localparam int BYTE_W   = 8;
  localparam int STD_ID_W = 11;
  localparam int EXT_ID_W = 29;
  localparam int DLC_W    = 4;

  typedef struct packed {
    logic                ext;
    logic [EXT_ID_W-1:0] id;
    logic                rtr;
    logic [DLC_W-1:0]    dlc;
    logic [BYTE_W-1:0]   d0;
    logic [BYTE_W-1:0]   d1;
  } af_frame_t;
endpackage

// File: rtl/af_regs.sv
module af_regs #(
  parameter int NB = 4,
  parameter int BW = 8,
  localparam int W  = NB * BW,
  localparam int AW = $clog2(2 * NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  output logic [W-1:0]  code,
  output logic [W-1:0]  mask
);
  // byte n sits at the top end of the word for n = 0
  for (genvar n = 0; n < NB; n++) begin : g_byte
    localparam int LSB = (NB - 1 - n) * BW;
    localparam logic [AW-1:0] CODE_A = AW'(n);
    localparam logic [AW-1:0] MASK_A = AW'(NB + n);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        code[LSB +: BW] <= '0;
        mask[LSB +: BW] <= '1;
      end else if (we) begin
        if (addr == CODE_A) code[LSB +: BW] <= wdata;
        if (addr == MASK_A) mask[LSB +: BW] <= wdata;
      end
    end

    assert_code_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == CODE_A) |=> code[LSB +: BW] == $past(wdata));
    assert_mask_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == MASK_A) |=> mask[LSB +: BW] == $past(wdata));
  end
endmodule

// File: rtl/af_vec.sv
module af_vec
  import can_af_pkg::*;
#(
  parameter int W = 32
) (
  input  af_frame_t    frm,
  output logic [W-1:0] vec,
  output logic [W-1:0] care
);
  localparam int STD_PAD = W - STD_ID_W - 1 - 2 * BYTE_W;
  localparam int EXT_PAD = W - EXT_ID_W - 1;

  logic has_d0, has_d1;
  assign has_d0 = (frm.dlc != '0);
  assign has_d1 = (frm.dlc > DLC_W'(1));

  always_comb begin
    if (frm.ext) begin
      vec  = {frm.id, frm.rtr, {EXT_PAD{1'b0}}};
      care = {{(EXT_ID_W + 1){1'b1}}, {EXT_PAD{1'b0}}};
    end else begin
      vec  = {frm.id[STD_ID_W-1:0], frm.rtr, frm.d0, frm.d1, {STD_PAD{1'b0}}};
      care = {{(STD_ID_W + 1){1'b1}}, {BYTE_W{has_d0}}, {BYTE_W{has_d1}},
              {STD_PAD{1'b0}}};
    end
  end
endmodule

// File: rtl/af_match.sv
module af_match #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] vec,
  input  logic [W-1:0] care,
  input  logic [W-1:0] code,
  input  logic [W-1:0] mask,
  output logic         res_valid,
  output logic         res_accept
);
  logic hit;
  assign hit = ~|((vec ^ code) & care & ~mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
    end else begin
      res_valid  <= in_valid;
      res_accept <= in_valid & hit;
    end
  end

  assert_accept_in_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> res_valid);
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);
  assert_open_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (&mask)) |=> res_accept);
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_af_pkg::*;
#(
  parameter int NB = 4,
  localparam int W  = NB * BYTE_W,
  localparam int AW = $clog2(2 * NB)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [BYTE_W-1:0]   cfg_wdata,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_ext,
  input  logic [EXT_ID_W-1:0] in_id,
  input  logic                in_rtr,
  input  logic [DLC_W-1:0]    in_dlc,
  input  logic [BYTE_W-1:0]   in_data0,
  input  logic [BYTE_W-1:0]   in_data1,
  output logic                res_valid,
  output logic                res_accept
);
  logic [W-1:0] code, mask, vec, care;
  af_frame_t frm;

  assign in_ready = 1'b1;
  assign frm = '{ext: in_ext, id: in_id, rtr: in_rtr, dlc: in_dlc,
                 d0: in_data0, d1: in_data1};

  af_regs #(.NB(NB), .BW(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .code(code), .mask(mask)
  );

  af_vec #(.W(W)) u_vec (.frm(frm), .vec(vec), .care(care));

  af_match #(.W(W)) u_match (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vec(vec), .care(care),
    .code(code), .mask(mask), .res_valid(res_valid), .res_accept(res_accept)
  );

  assert_res_only_after_transfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_ready));
endmodule

// File: tb/can_accept_filter_test.sv
module can_accept_filter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic in_valid = 1'b0, in_ext = 1'b0, in_rtr = 1'b0;
  logic [28:0] in_id = '0;
  logic [3:0] in_dlc = '0;
  logic [7:0] in_data0 = '0, in_data1 = '0;
  logic in_ready, res_valid, res_accept;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  can_accept_filter uut (.*);

  typedef struct packed {
    logic ext; logic [28:0] id; logic rtr; logic [3:0] dlc;
    logic [7:0] d0; logic [7:0] d1; logic [31:0] code; logic [31:0] mask;
    logic exp;
  } vec_t;

  function automatic logic [31:0] stdc(logic [10:0] id, logic rtr, logic [7:0] a, logic [7:0] b);
    return {id, rtr, a, b, 4'h0};
  endfunction
  function automatic logic [31:0] extc(logic [28:0] id, logic rtr);
    return {id, rtr, 2'b00};
  endfunction

  localparam logic [31:0] SC = stdc(11'h123, 1'b0, 8'hAA, 8'h55);
  localparam logic [31:0] EC = extc(29'h1ABCDEF1, 1'b0);
  localparam int N = 16;
  localparam vec_t TBL [N] = '{
    '{1'b0, 29'h0000077, 1'b1, 4'd8, 8'h01, 8'h02, 32'h0, 32'hFFFFFFFF, 1'b1}, // R3 open
    '{1'b0, 29'h0000123, 1'b0, 4'd2, 8'hAA, 8'h55, SC, 32'h0, 1'b1},          // R4 exact
    '{1'b0, 29'h0000124, 1'b0, 4'd2, 8'hAA, 8'h55, SC, 32'h0, 1'b0},          // R4 id
    '{1'b0, 29'h0000123, 1'b1, 4'd2, 8'hAA, 8'h55, SC, 32'h0, 1'b0},          // R4 rtr
    '{1'b0, 29'h0000123, 1'b0, 4'd2, 8'hAA, 8'h56, SC, 32'h0, 1'b0},          // R4 byte1
    '{1'b0, 29'h0000123, 1'b0, 4'd1, 8'hAA, 8'h56, SC, 32'h0, 1'b1},          // R5 dlc1
    '{1'b0, 29'h0000123, 1'b0, 4'd0, 8'hAB, 8'h56, SC, 32'h0, 1'b1},          // R5 dlc0
    '{1'b0, 29'h0000123, 1'b0, 4'd1, 8'hAB, 8'h55, SC, 32'h0, 1'b0},          // R5 byte0
    '{1'b0, 29'h0000124, 1'b0, 4'd2, 8'hAA, 8'h55, SC, 32'h00E00000, 1'b1},   // R3 cover
    '{1'b0, 29'h0000124, 1'b0, 4'd2, 8'hAA, 8'h55, SC, 32'h00C00000, 1'b0},   // R3 partial
    '{1'b0, 29'h0000123, 1'b0, 4'd2, 8'hAA, 8'h55, SC | 32'hF, 32'h0, 1'b1},  // R4 pad
    '{1'b1, 29'h1ABCDEF1, 1'b0, 4'd8, 8'h3C, 8'hC3, EC, 32'h0, 1'b1},         // R6 exact
    '{1'b1, 29'h1ABCDEF0, 1'b0, 4'd8, 8'h3C, 8'hC3, EC, 32'h0, 1'b0},         // R6 id
    '{1'b1, 29'h1ABCDEF1, 1'b1, 4'd8, 8'h3C, 8'hC3, EC, 32'h0, 1'b0},         // R6 rtr
    '{1'b1, 29'h1ABCDEF1, 1'b0, 4'd2, 8'h00, 8'hFF, EC | 32'h3, 32'h0, 1'b1}, // R6 pad
    '{1'b1, 29'h0ABCDEF1, 1'b0, 4'd0, 8'h00, 8'h00, EC, 32'h0, 1'b0}          // R6 top id bit
  };

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load(logic [31:0] c, logic [31:0] m);
    for (int k = 0; k < 4; k++) begin
      wr(3'(k), c[31-8*k -: 8]);
      wr(3'(4+k), m[31-8*k -: 8]);
    end
  endtask

  task automatic put(logic e, logic [28:0] id, logic r, logic [3:0] l, logic [7:0] a, logic [7:0] b);
    in_valid = 1'b1; in_ext = e; in_id = id; in_rtr = r; in_dlc = l;
    in_data0 = a; in_data1 = b;
  endtask

  // present one frame and sample the decision one clock later
  task automatic send(string tag, logic e, logic [28:0] id, logic r, logic [3:0] l,
                      logic [7:0] a, logic [7:0] b, logic exp);
    @(negedge clk);
    put(e, id, r, l, a, b);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, res_valid, 1'b1);
    chk({tag, " accept"}, res_accept, exp);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 res_valid after reset", res_valid, 1'b0);
    chk("R1 res_accept after reset", res_accept, 1'b0);
    chk("R8 in_ready", in_ready, 1'b1);
    send("R1 open ext", 1'b1, 29'h15555555, 1'b1, 4'd3, 8'h12, 8'h34, 1'b1);
    send("R1 open std", 1'b0, 29'h00007FF, 1'b0, 4'd8, 8'hFF, 8'h00, 1'b1);
    @(negedge clk);
    chk("R2 idle after pulse", res_valid, 1'b0);

    // table walk
    for (int i = 0; i < N; i++) begin
      load(TBL[i].code, TBL[i].mask);
      send($sformatf("table %0d", i), TBL[i].ext, TBL[i].id, TBL[i].rtr,
           TBL[i].dlc, TBL[i].d0, TBL[i].d1, TBL[i].exp);
    end

    // R7 byte order: mask byte at address 7 covers bits 7:0 (data byte 1 low nibble)
    load(SC, 32'h0);
    send("R7 before mask write", 1'b0, 29'h123, 1'b0, 4'd2, 8'hAA, 8'h56, 1'b0);
    wr(3'd7, 8'h30);
    send("R7 low mask byte", 1'b0, 29'h123, 1'b0, 4'd2, 8'hAA, 8'h56, 1'b1);
    wr(3'd4, 8'h00);
    send("R7 top mask byte kept", 1'b0, 29'h523, 1'b0, 4'd2, 8'hAA, 8'h55, 1'b0);

    // R8 back-to-back transfers with alternating outcomes
    @(negedge clk);
    put(1'b0, 29'h123, 1'b0, 4'd2, 8'hAA, 8'h55);
    @(negedge clk);
    chk("R8 first valid", res_valid, 1'b1);
    chk("R8 first accept", res_accept, 1'b1);
    put(1'b0, 29'h124, 1'b0, 4'd2, 8'hAA, 8'h55);
    @(negedge clk);
    chk("R8 second valid", res_valid, 1'b1);
    chk("R8 second reject", res_accept, 1'b0);
    put(1'b0, 29'h123, 1'b0, 4'd2, 8'hAA, 8'h55);
    @(negedge clk);
    chk("R8 third valid", res_valid, 1'b1);
    chk("R8 third accept", res_accept, 1'b1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R2 single cycle pulse", res_valid, 1'b0);
    chk("R2 accept low when idle", res_accept, 1'b0);

    // R1 reset restores the open filter
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    send("R1 open after re-reset", 1'b0, 29'h124, 1'b1, 4'd2, 8'h00, 8'h00, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule